// File: doc/BRIEF.md
# Dual-Device Three-Wire SPI Master

This block is a register-controlled serial master for two converter chips that share one serial clock. Each chip has its own active-low select and its own bidirectional data pin, brought out as a common output value, a per-device output enable and a per-device input. A single write to the transmit register launches one 24-bit frame. The frame consists of a read/write flag, two length bits (always zero here, one data byte), five zero bits, an 8-bit register address and one data byte. The chips whose select bits are set in the same word take part, and both can take part in the same frame.

On a read frame the master stops driving the data pins for the final eight bit times, and each selected chip returns its register value on its own pin. The block shifts in both replies at the same time and packs them into one receive word, device A in the low byte and device B in the next byte. A configuration register sets the serial clock rate and drives one active-low reset line per chip. A status register exposes a busy flag so software can tell when the next frame may be written.

Top module: `dual_spi_master`

## Requirements
- R1: A write to the transmit register (address 1) while idle starts a frame. On the clock edge that accepts it, the busy flag rises. Each select output `spi_cs_n[i]` goes low only if bit 24+i of the written word is 1 (bit 24 selects device A, bit 25 selects device B).
- R2: The frame is bits [23:0] of the transmit word, sent MSB first on `spi_sdo`. Bit 23 is the read flag (1 = read, 0 = write). A new bit appears on each falling serial-clock edge, and the last bit is held until the frame ends.
- R3: `spi_sclk` is low when idle. Every half-period lasts (D+1) bus clocks, where D is configuration bits [7:0]. The frame has 24 rising edges, and on each one the slave samples the bit.
- R4: The selects go low one half-period before the first rising edge. They return high, and busy falls, one half-period after the final falling edge, so a frame lasts 49·(D+1) bus clocks.
- R5: Each selected device's `spi_sdo_oe` bit is 1 during a frame. On a read frame it drops to 0 at the falling edge that ends bit 15, and it stays 0 for the last 8 bit times. On a write frame it stays 1 to the end. All enables are 0 when idle.
- R6: On a read, the 8 bits each selected device returns on `spi_sdi[i]` are captured MSB first on the last 8 rising edges. Reading address 2 returns device A's byte in bits [7:0], device B's byte in bits [15:8], and zero in bits [31:16].
- R7: A byte lane whose select bit was clear in a read frame keeps its previous receive value. A write frame changes neither lane.
- R8: A write to the transmit register while busy is ignored. The running frame continues unchanged.
- R9: The configuration register (address 0) holds D in bits [7:0] and the reset outputs in bits [8] (device A) and [9] (device B). `dev_rst_n` follows those bits. After bus reset the register is zero, so both devices are held in reset.
- R10: Reading address 3 returns busy in bit 0 and zero elsewhere. Reading address 1 returns zero. Read data appears on `bus_rdata` one clock after `bus_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| spi_sclk | output | 1 | Shared serial clock |
| spi_cs_n | output | 2 | Per-device active-low select |
| spi_sdo | output | 1 | Serial data driven toward both devices |
| spi_sdo_oe | output | 2 | Per-device data pin output enable |
| spi_sdi | input | 2 | Per-device data pin input |
| dev_rst_n | output | 2 | Per-device active-low reset |

## Verification
The hardest situation to reach from the ports is the turnaround: the bench has to present each device's reply bit by bit, exactly in the half-periods after the master has released the pin, while the two devices return different bytes. The bench's reference model knows the tick count of every cycle, so it drives `spi_sdi` from that count for the read window and puts a deliberately wrong value on the pin outside it. Frames that select only one device, a divider of zero, and a transmit write issued mid-frame complete the picture for lane retention and the ignore rule.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  typedef enum logic [1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_TX   = 2'd1,
    ADDR_RX   = 2'd2,
    ADDR_STAT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/dspi_tick.sv
// Half-period strobe generator: one pulse every (div+1) clocks while running.
module dspi_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= (cnt == div) ? '0 : cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == div);
endmodule

// File: rtl/dspi_lane.sv
// One capture lane: shifts in the reply bits and commits the byte at frame end.
module dspi_lane #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic              commit,
  input  logic              sel,
  input  logic              sdi,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      rx_byte <= '0;
    end else begin
      if (sample) sh <= {sh[BYTE_W-2:0], sdi};
      if (commit && sel) rx_byte <= sh;
    end
  end

  p_keep_lane_r7: assert property (@(posedge clk) disable iff (rst)
    (!(commit && sel)) |=> $stable(rx_byte));
endmodule

// File: rtl/dspi_engine.sv
// Frame sequencer: select timing, serial clock, shift-out, turnaround and capture.
module dspi_engine #(
  parameter int NUM_DEV = 2,
  parameter int FRAME_W = 24,
  parameter int BYTE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      accept,
  input  logic [FRAME_W-1:0]        frame_in,
  input  logic [NUM_DEV-1:0]        mask_in,
  input  logic                      tick,
  input  logic [NUM_DEV-1:0]        sdi,
  output logic                      busy,
  output logic                      sclk,
  output logic [NUM_DEV-1:0]        cs_n,
  output logic                      sdo,
  output logic [NUM_DEV-1:0]        sdo_oe,
  output logic [NUM_DEV*BYTE_W-1:0] rx_data
);
  localparam int TICKS    = 2 * FRAME_W + 1;
  localparam int CNT_W    = $clog2(TICKS + 1);
  localparam int RD_START = 2 * (FRAME_W - BYTE_W);
  localparam logic [CNT_W-1:0] LAST_T  = CNT_W'(TICKS - 1);
  localparam logic [CNT_W-1:0] HOLD_T  = CNT_W'(TICKS - 2);
  localparam logic [CNT_W-1:0] RD_FALL = CNT_W'(RD_START - 1);
  localparam logic [CNT_W-1:0] RD_OFF  = CNT_W'(RD_START);

  logic [FRAME_W-1:0] shreg;
  logic [NUM_DEV-1:0] mask;
  logic               rnw;
  logic [CNT_W-1:0]   tcnt;
  logic               sample;
  logic               commit;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sclk   <= 1'b0;
      cs_n   <= '1;
      sdo_oe <= '0;
      shreg  <= '0;
      mask   <= '0;
      rnw    <= 1'b0;
      tcnt   <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      mask   <= mask_in;
      cs_n   <= ~mask_in;
      sdo_oe <= mask_in;
      shreg  <= frame_in;
      rnw    <= frame_in[FRAME_W-1];
      tcnt   <= '0;
    end else if (busy && tick) begin
      tcnt <= tcnt + 1'b1;
      if (tcnt == LAST_T) begin
        busy   <= 1'b0;
        cs_n   <= '1;
        sdo_oe <= '0;
        sclk   <= 1'b0;
      end else begin
        sclk <= ~sclk;
        if (tcnt[0]) begin
          if (tcnt != HOLD_T) shreg <= shreg << 1;
          if (rnw && tcnt == RD_FALL) sdo_oe <= '0;
        end
      end
    end
  end

  assign sdo    = shreg[FRAME_W-1];
  assign sample = busy && tick && rnw && !tcnt[0] && (tcnt >= RD_OFF) && (tcnt < LAST_T);
  assign commit = busy && tick && rnw && (tcnt == LAST_T);

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_lane
    dspi_lane #(.BYTE_W(BYTE_W)) i_lane (
      .clk     (clk),
      .rst     (rst),
      .sample  (sample),
      .commit  (commit),
      .sel     (mask[i]),
      .sdi     (sdi[i]),
      .rx_byte (rx_data[i*BYTE_W +: BYTE_W])
    );
  end

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);
  p_sclk_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sclk));
  p_cs_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n == '1));
  p_oe_read_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && rnw && tcnt >= RD_OFF) |-> (sdo_oe == '0));
  p_oe_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sdo_oe == '0));
endmodule

// File: rtl/dual_spi_master.sv
module dual_spi_master #(
  parameter int NUM_DEV = 2,
  parameter int FRAME_W = 24,
  parameter int BYTE_W  = 8,
  parameter int DIV_W   = 8,
  parameter int BUS_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               spi_sclk,
  output logic [NUM_DEV-1:0] spi_cs_n,
  output logic               spi_sdo,
  output logic [NUM_DEV-1:0] spi_sdo_oe,
  input  logic [NUM_DEV-1:0] spi_sdi,
  output logic [NUM_DEV-1:0] dev_rst_n
);
  import dspi_pkg::*;

  localparam int RST_LSB = DIV_W;
  localparam int RX_W    = NUM_DEV * BYTE_W;

  logic [DIV_W-1:0]   cfg_div;
  logic [NUM_DEV-1:0] cfg_rst_n;
  logic               busy;
  logic               accept;
  logic               tick;
  logic [RX_W-1:0]    rx_data;
  logic [BUS_W-1:0]   rd_nxt;
  logic               unused_bits;

  assign accept = bus_wr && (reg_addr_e'(bus_addr) == ADDR_TX) && !busy;
  assign unused_bits = ^{bus_wdata[BUS_W-1:FRAME_W+NUM_DEV],
                         bus_wdata[BUS_W-1:RST_LSB+NUM_DEV]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_div   <= '0;
      cfg_rst_n <= '0;
    end else if (bus_wr && reg_addr_e'(bus_addr) == ADDR_CFG) begin
      cfg_div   <= bus_wdata[DIV_W-1:0];
      cfg_rst_n <= bus_wdata[RST_LSB +: NUM_DEV];
    end
  end

  assign dev_rst_n = cfg_rst_n;

  always_comb begin
    rd_nxt = '0;
    unique case (reg_addr_e'(bus_addr))
      ADDR_CFG: begin
        rd_nxt[DIV_W-1:0]           = cfg_div;
        rd_nxt[RST_LSB +: NUM_DEV]  = cfg_rst_n;
      end
      ADDR_TX:   rd_nxt = '0;
      ADDR_RX:   rd_nxt[RX_W-1:0] = rx_data;
      ADDR_STAT: rd_nxt[0] = busy;
      default:   rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end

  dspi_tick #(.DIV_W(DIV_W)) i_tick (
    .clk   (clk),
    .rst   (rst),
    .run   (busy),
    .clear (accept),
    .div   (cfg_div),
    .tick  (tick)
  );

  dspi_engine #(
    .NUM_DEV (NUM_DEV),
    .FRAME_W (FRAME_W),
    .BYTE_W  (BYTE_W)
  ) i_engine (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .frame_in (bus_wdata[FRAME_W-1:0]),
    .mask_in  (bus_wdata[FRAME_W +: NUM_DEV]),
    .tick     (tick),
    .sdi      (spi_sdi),
    .busy     (busy),
    .sclk     (spi_sclk),
    .cs_n     (spi_cs_n),
    .sdo      (spi_sdo),
    .sdo_oe   (spi_sdo_oe),
    .rx_data  (rx_data)
  );

  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && spi_cs_n == ~$past(bus_wdata[FRAME_W +: NUM_DEV])));
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && reg_addr_e'(bus_addr) == ADDR_TX)
      |=> (spi_cs_n == $past(spi_cs_n) || spi_cs_n == '1));
  p_rst_out_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && reg_addr_e'(bus_addr) == ADDR_CFG)
      |=> (dev_rst_n == $past(bus_wdata[RST_LSB +: NUM_DEV])));
endmodule

// File: tb/test_dual_spi_master.sv
module test_dual_spi_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        spi_sclk;
  logic [1:0]  spi_cs_n;
  logic        spi_sdo;
  logic [1:0]  spi_sdo_oe;
  logic [1:0]  spi_sdi = 2'b00;
  logic [1:0]  dev_rst_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  bit          m_busy;
  int          m_n;
  logic [23:0] m_frame;
  logic [1:0]  m_mask;
  bit          m_rnw;
  logic [7:0]  m_div;
  logic [1:0]  m_rst;
  logic [15:0] m_rx;
  logic [31:0] m_rdata;
  logic [7:0]  dev_a = 8'h00;
  logic [7:0]  dev_b = 8'h00;

  always #2.5 clk = ~clk;

  dual_spi_master i_dual_spi_master (
    .clk, .rst, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .spi_sclk, .spi_cs_n, .spi_sdo, .spi_sdo_oe, .spi_sdi, .dev_rst_n
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // model: advances on the same edges as the design
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_n = 0; m_frame = 0; m_mask = 0; m_rnw = 0;
      m_div = 0; m_rst = 0; m_rx = 0; m_rdata = 0;
    end else begin
      case (bus_addr)
        2'd0: m_rdata = {22'd0, m_rst, m_div};
        2'd1: m_rdata = 32'd0;
        2'd2: m_rdata = {16'd0, m_rx};
        default: m_rdata = {31'd0, m_busy};
      endcase
      if (m_busy) begin
        m_n++;
        if (m_n == 49 * (int'(m_div) + 1)) begin
          m_busy = 0;
          if (m_rnw) begin
            if (m_mask[0]) m_rx[7:0]  = dev_a;
            if (m_mask[1]) m_rx[15:8] = dev_b;
          end
        end
      end else if (bus_wr && bus_addr == 2'd1) begin
        m_busy = 1; m_n = 0;
        m_frame = bus_wdata[23:0];
        m_mask = bus_wdata[25:24];
        m_rnw = bus_wdata[23];
      end
      if (bus_wr && bus_addr == 2'd0) begin
        m_div = bus_wdata[7:0];
        m_rst = bus_wdata[9:8];
      end
    end
  end

  // compare every cycle and drive the device replies
  always @(negedge clk) begin
    if (!rst && !done) begin
      int k;
      int idx;
      logic       e_sclk;
      logic [1:0] e_cs;
      logic [1:0] e_oe;
      k = m_busy ? m_n / (int'(m_div) + 1) : 0;
      e_sclk = m_busy && (k % 2 == 1) && (k <= 47);
      e_cs   = m_busy ? ~m_mask : 2'b11;
      e_oe   = (m_busy && !(m_rnw && k >= 32)) ? m_mask : 2'b00;
      check(spi_sclk === e_sclk, "R3 sclk", {31'd0, spi_sclk}, {31'd0, e_sclk});
      check(spi_cs_n === e_cs, "R1/R4 cs_n", {30'd0, spi_cs_n}, {30'd0, e_cs});
      check(spi_sdo_oe === e_oe, "R5 sdo_oe", {30'd0, spi_sdo_oe}, {30'd0, e_oe});
      check(dev_rst_n === m_rst, "R9 dev_rst_n", {30'd0, dev_rst_n}, {30'd0, m_rst});
      check(bus_rdata === m_rdata, "R10/R6 rdata", bus_rdata, m_rdata);
      if (m_busy) begin
        idx = (k / 2 < 23) ? k / 2 : 23;
        check(spi_sdo === m_frame[23-idx], "R2 sdo", {31'd0, spi_sdo}, {31'd0, m_frame[23-idx]});
      end
      if (m_busy && m_rnw && k >= 32 && k <= 47) begin
        idx = (k - 32) / 2;
        spi_sdi = {dev_b[7-idx], dev_a[7-idx]};
      end else begin
        spi_sdi = 2'b10;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    rd(2'd0, v);
    check(v === 32'd0, "R9 cfg after reset", v, 32'd0);
    check(dev_rst_n === 2'b00, "R9 resets held", {30'd0, dev_rst_n}, 32'd0);
    rd(2'd2, v);
    check(v === 32'd0, "R6 rx after reset", v, 32'd0);
    // release resets, divider 3
    wr(2'd0, 32'h0000_0303);
    rd(2'd0, v);
    check(v === 32'h0000_0303, "R9 cfg readback", v, 32'h303);
    check(dev_rst_n === 2'b11, "R9 resets released", {30'd0, dev_rst_n}, 32'd3);
    // R2/R7: write frame to both devices leaves rx untouched
    dev_a = 8'hEE; dev_b = 8'hDD;
    wr(2'd1, 32'h0300_5CA5);
    rd(2'd3, v);
    check(v === 32'd1, "R10 busy during frame", v, 32'd1);
    wait_idle();
    rd(2'd2, v);
    check(v === 32'd0, "R7 write frame keeps rx", v, 32'd0);
    rd(2'd1, v);
    check(v === 32'd0, "R10 tx reads zero", v, 32'd0);
    // R6: read both devices
    dev_a = 8'h08; dev_b = 8'h5A;
    wr(2'd1, 32'h0380_7200);
    wait_idle();
    rd(2'd2, v);
    check(v === 32'h0000_5A08, "R6 dual read", v, 32'h5A08);
    // R7: device A only
    dev_a = 8'hC3; dev_b = 8'hFF;
    wr(2'd1, 32'h0180_1000);
    wait_idle();
    rd(2'd2, v);
    check(v === 32'h0000_5AC3, "R7 lane B kept", v, 32'h5AC3);
    // R8: divider 0, device B only, a second tx write mid-frame
    wr(2'd0, 32'h0000_0300);
    dev_b = 8'h81; dev_a = 8'h11;
    wr(2'd1, 32'h0280_3300);
    repeat (10) @(negedge clk);
    wr(2'd1, 32'h0100_7F3C);
    wait_idle();
    rd(2'd2, v);
    check(v === 32'h0000_81C3, "R8 ignored write, R7 lane A kept", v, 32'h81C3);
    rd(2'd3, v);
    check(v === 32'd0, "R10 idle status", v, 32'd0);
    // R3/R5: divider 1, write frame to device B, then no-select frame
    wr(2'd0, 32'h0000_0101);
    wr(2'd1, 32'h0200_4096);
    wait_idle();
    wr(2'd1, 32'h0080_0000);
    wait_idle();
    rd(2'd2, v);
    check(v === 32'h0000_81C3, "R7 unselected read keeps rx", v, 32'h81C3);
    check(dev_rst_n === 2'b01, "R9 partial reset", {30'd0, dev_rst_n}, 32'd1);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule